// File: doc/BRIEF.md
# Write-Masked PHY Configuration Port

This block is a 32-bit register slave that sits between a host bus and the configuration space of a multi-lane PHY. Every write carries its own per-bit enable in the upper half of the word. Only the lower-half bits whose enable is set change, so software can update one field without first reading the register back.

A configuration register holds a 4-bit data value, a 6-bit target address and a commit strobe. A 0-to-1 transition of the strobe copies the data into a 64-entry internal configuration array. If the write that raises the strobe also changes the data or address, the commit is held back by one cycle, so that it uses the settled fields. A lane register drives one idle-force output per lane. A read-only status view reports PLL lock and PLL output state. A readback view exposes the array entry at the current address.

Top module: `phycfg_port`

## Requirements
- R1: On a write to the config register (select 0) or the lane register (select 1), bit x of the stored 16-bit value takes bit x of the word only when bit x+16 is 1; every other stored bit keeps its value, and registers that are not selected do not change.
- R2: A read (bus_valid=1, bus_write=0) returns the stored 16-bit value of the selected register in bits 15:0, with bits 31:16 equal to zero; bus_rdata is zero whenever no read is presented.
- R3: In the config register, bits 10:7 are the config data, bits 6:1 the config address and bit 0 the commit strobe.
- R4: A write that takes the strobe from 0 to 1 without changing bits 10:1 commits the data to the array entry at the address at that clock edge.
- R5: No commit happens while the strobe is already 1 (rewriting it as 1 or changing fields under it) or when it falls to 0.
- R6: A write that raises the strobe and also changes bits 10:1 commits one cycle later, using the register's fields as they stand after that write.
- R7: Output lane_idle[i] equals bit 3+i of the lane register, for i from 0 to LANES-1.
- R8: The status view (select 2) reads pll_locked in bit 9 and pll_out_active in bit 10, with all other bits zero; writes to select 2 or 3 change nothing.
- R9: A synchronous reset clears the config register, the lane register, any pending commit and every array entry to zero.
- R10: The readback view (select 3) returns the current config address in bits 9:4 and the array entry at that address in bits 3:0, a 10-bit value with all higher bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Transaction present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Register select: 0 config, 1 lane, 2 status, 3 readback |
| bus_wdata | input | 32 | Write word: enables in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| pll_locked | input | 1 | PLL lock indication from the PHY |
| pll_out_active | input | 1 | PLL output active indication from the PHY |
| lane_idle | output | LANES (4) | Per-lane idle-force controls |

## Verification
The assertions assume that bus_valid, bus_write, bus_sel and bus_wdata are known (not X) at every clock edge after reset, and that reset is held high at the first edge. They also assume that one transaction at most arrives per cycle. The bench drives every input from its own tasks at the falling edge, with fully defined values. Reset is asserted from time zero. Random words mix wide and narrow enable masks, so that strobe rises with settled fields, strobe rises with changed fields and held strobes all occur.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

   localparam int unsigned REG_W = 16;
   localparam int unsigned BUS_W = 2 * REG_W;

   typedef enum logic [1:0] {
      SEL_CFG  = 2'd0,
      SEL_LANE = 2'd1,
      SEL_STAT = 2'd2,
      SEL_RDBK = 2'd3
   } sel_e;

   function automatic logic [REG_W-1:0] masked_merge(
      input logic [REG_W-1:0] old_v,
      input logic [BUS_W-1:0] word
   );
      logic [REG_W-1:0] en;
      en = word[BUS_W-1:REG_W];
      return (old_v & ~en) | (word[REG_W-1:0] & en);
   endfunction

endpackage

// File: rtl/phycfg_mask_reg.sv
module phycfg_mask_reg
   import phycfg_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_word,
   output logic [REG_W-1:0] q,
   output logic [REG_W-1:0] d
);

   always_comb begin
      d = q;
      if (wr_en) d = masked_merge(q, wr_word);
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

   // R1: without a write the register holds
   assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(q));

   // R1: bits without an enable never move
   assert_masked_R1: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (((q ^ $past(q)) & ~$past(wr_word[BUS_W-1:REG_W])) == '0));

   // R9: reset leaves the register cleared
   assert_reset_R9: assert property (@(posedge clk)
      rst |=> (q == '0));

endmodule

// File: rtl/phycfg_commit.sv
module phycfg_commit
   import phycfg_pkg::*;
#(
   parameter int unsigned AW       = 6,
   parameter int unsigned DW       = 4,
   parameter int unsigned ADDR_LSB = 1,
   parameter int unsigned DATA_LSB = 7,
   parameter int unsigned STB_BIT  = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [REG_W-1:0] cfg_q,
   input  logic [REG_W-1:0] cfg_d,
   output logic             we,
   output logic [AW-1:0]    waddr,
   output logic [DW-1:0]    wdata
);

   logic [AW-1:0] q_addr, d_addr;
   logic [DW-1:0] q_data, d_data;
   logic          rise, settled, pend_q;

   assign q_addr  = cfg_q[ADDR_LSB +: AW];
   assign d_addr  = cfg_d[ADDR_LSB +: AW];
   assign q_data  = cfg_q[DATA_LSB +: DW];
   assign d_data  = cfg_d[DATA_LSB +: DW];
   assign rise    = !cfg_q[STB_BIT] && cfg_d[STB_BIT];
   assign settled = (q_addr == d_addr) && (q_data == d_data);

   always_ff @(posedge clk) begin
      if (rst) pend_q <= 1'b0;
      else     pend_q <= rise && !settled;
   end

   always_comb begin
      we    = pend_q || (rise && settled);
      waddr = pend_q ? q_addr : d_addr;
      wdata = pend_q ? q_data : d_data;
   end

   // R5: a strobe already high never commits on its own
   assert_norepeat_R5: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[STB_BIT] && !pend_q) |-> !we);

   // R6: a rise with moving fields commits next cycle with the new fields
   assert_defer_R6: assert property (@(posedge clk) disable iff (rst)
      (rise && !settled) |=> (we && waddr == $past(d_addr) && wdata == $past(d_data)));

endmodule

// File: rtl/phycfg_cfg_array.sv
module phycfg_cfg_array #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DW-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (rst)                        ent_q <= '0;
         else if (we && waddr == AW'(i)) ent_q <= wdata;
      end
      assign mem[i] = ent_q;
   end

   assign rdata = mem[raddr];

   // R4: a commit lands in the addressed entry
   assert_write_R4: assert property (@(posedge clk) disable iff (rst)
      we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/phycfg_port.sv
module phycfg_port
   import phycfg_pkg::*;
#(
   parameter int unsigned LANES    = 4,
   parameter int unsigned CFG_AW   = 6,
   parameter int unsigned CFG_DW   = 4,
   parameter int unsigned IDLE_LSB = 3,
   parameter int unsigned LOCK_BIT = 9,
   parameter int unsigned OUT_BIT  = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bus_valid,
   input  logic             bus_write,
   input  logic [1:0]       bus_sel,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic             pll_locked,
   input  logic             pll_out_active,
   output logic [LANES-1:0] lane_idle
);

   localparam int unsigned ADDR_LSB = 1;
   localparam int unsigned DATA_LSB = ADDR_LSB + CFG_AW;
   localparam int unsigned RB_W     = CFG_AW + CFG_DW;

   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("LANES must be 1 to 4");
   end
   if (DATA_LSB + CFG_DW > REG_W) begin : g_bad_fields
      $error("config fields exceed register width");
   end
   if (IDLE_LSB + LANES > REG_W || OUT_BIT >= REG_W || LOCK_BIT >= REG_W) begin : g_bad_bits
      $error("bit position outside register");
   end

   logic             wr_cfg, wr_lane, rd;
   logic [REG_W-1:0] cfg_q, cfg_d, lane_q, lane_d;
   logic             we;
   logic [CFG_AW-1:0] waddr;
   logic [CFG_DW-1:0] wdata, rb_data;

   assign wr_cfg  = bus_valid && bus_write && (bus_sel == SEL_CFG);
   assign wr_lane = bus_valid && bus_write && (bus_sel == SEL_LANE);
   assign rd      = bus_valid && !bus_write;

   phycfg_mask_reg u_cfg (
      .clk(clk), .rst(rst), .wr_en(wr_cfg), .wr_word(bus_wdata),
      .q(cfg_q), .d(cfg_d)
   );

   phycfg_mask_reg u_lane (
      .clk(clk), .rst(rst), .wr_en(wr_lane), .wr_word(bus_wdata),
      .q(lane_q), .d(lane_d)
   );

   phycfg_commit #(
      .AW(CFG_AW), .DW(CFG_DW), .ADDR_LSB(ADDR_LSB), .DATA_LSB(DATA_LSB), .STB_BIT(0)
   ) u_commit (
      .clk(clk), .rst(rst), .cfg_q(cfg_q), .cfg_d(cfg_d),
      .we(we), .waddr(waddr), .wdata(wdata)
   );

   phycfg_cfg_array #(.AW(CFG_AW), .DW(CFG_DW)) u_arr (
      .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(cfg_q[ADDR_LSB +: CFG_AW]), .rdata(rb_data)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_idle[i] = lane_q[IDLE_LSB + i];
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         unique case (sel_e'(bus_sel))
            SEL_CFG:  bus_rdata[REG_W-1:0] = cfg_q;
            SEL_LANE: bus_rdata[REG_W-1:0] = lane_q;
            SEL_STAT: begin
               bus_rdata[LOCK_BIT] = pll_locked;
               bus_rdata[OUT_BIT]  = pll_out_active;
            end
            SEL_RDBK: bus_rdata[RB_W-1:0] = {cfg_q[ADDR_LSB +: CFG_AW], rb_data};
            default:  bus_rdata = '0;
         endcase
      end
   end

   // R2: nothing is driven without a read
   assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !rd |-> (bus_rdata == '0));

endmodule

// File: tb/sim_phycfg_port.sv
`timescale 1ns/1ps
module sim_phycfg_port;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pll_locked = 1'b0, pll_out_active = 1'b0;
   logic [3:0]  lane_idle;

   int checks = 0, errors = 0;

   logic [15:0] m_cfg, m_lane;
   logic [3:0]  m_mem [64];
   logic        m_pend;

   always #10 clk = ~clk;

   phycfg_port u0 (
      .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pll_locked(pll_locked), .pll_out_active(pll_out_active), .lane_idle(lane_idle)
   );

   function automatic logic [15:0] merge(input logic [15:0] o, input logic [31:0] w);
      return (o & ~w[31:16]) | (w[15:0] & w[31:16]);
   endfunction

   function automatic void model_clear();
      m_cfg = '0; m_lane = '0; m_pend = 1'b0;
      for (int i = 0; i < 64; i++) m_mem[i] = '0;
   endfunction

   // one clock edge of the reference model
   function automatic void model_edge(input logic wr, input logic [1:0] s, input logic [31:0] w);
      logic [15:0] nc;
      logic        rise, same;
      nc = m_cfg;
      if (m_pend) m_mem[m_cfg[6:1]] = m_cfg[10:7];
      if (wr && s == 2'd0) nc = merge(m_cfg, w);
      if (wr && s == 2'd1) m_lane = merge(m_lane, w);
      rise = !m_cfg[0] && nc[0];
      same = (nc[10:1] == m_cfg[10:1]);
      if (rise && same) m_mem[nc[6:1]] = nc[10:7];
      m_pend = rise && !same;
      m_cfg  = nc;
   endfunction

   function automatic logic [31:0] exp_read(input logic [1:0] s);
      logic [31:0] r;
      r = '0;
      case (s)
         2'd0: r[15:0] = m_cfg;
         2'd1: r[15:0] = m_lane;
         2'd2: begin r[9] = pll_locked; r[10] = pll_out_active; end
         default: r[9:0] = {m_cfg[6:1], m_mem[m_cfg[6:1]]};
      endcase
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] w);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_sel = s; bus_wdata = w;
      @(posedge clk);
      model_edge(1'b1, s, w);
   endtask

   task automatic rd(input logic [1:0] s, input string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_sel = s; bus_wdata = $urandom;
      #1;
      chk(tag, bus_rdata, exp_read(s));
      if (s == 2'd1) chk("R7 lane_idle", {28'd0, lane_idle}, {28'd0, m_lane[6:3]});
      @(posedge clk);
      model_edge(1'b0, s, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; bus_valid = 1'b0;
      @(posedge clk);
      model_clear();
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_clear();
      do_reset();

      // R9 reset state
      rd(2'd0, "R9 cfg after reset");
      rd(2'd1, "R9 lane after reset");
      rd(2'd3, "R9 readback after reset");
      @(negedge clk); bus_valid = 1'b0; #1;
      chk("R2 no read gives zero", bus_rdata, 32'd0);

      // R1 masked writes
      wr(2'd1, 32'h00F0_FFFF);
      rd(2'd1, "R1 lane partial mask");
      wr(2'd1, 32'h0018_0000);
      rd(2'd1, "R1 lane clear bits 4,3 / R7");
      wr(2'd0, 32'h0000_FFFF);
      rd(2'd0, "R1 zero mask leaves cfg");

      // R3/R4 settle fields then raise strobe
      wr(2'd0, {16'h07FE, 16'(4'hA << 7) | 16'(6'd5 << 1)});
      rd(2'd3, "R4 no commit before strobe");
      wr(2'd0, 32'h0001_0001);
      rd(2'd3, "R4 committed addr5 data A");
      rd(2'd0, "R3 cfg field layout");

      // R5 held strobe, rewrite 1, fall
      wr(2'd0, {16'h0780, 16'(4'h3 << 7)});
      rd(2'd3, "R5 field change under held strobe");
      wr(2'd0, 32'h0001_0001);
      wr(2'd0, 32'h0001_0000);
      wr(2'd0, {16'h0780, 16'(4'hA << 7)});
      rd(2'd3, "R5 rewrite and fall no commit");

      // R6 strobe rise together with field change
      wr(2'd0, {16'h07FF, 16'(4'h6 << 7) | 16'(6'd9 << 1) | 16'd1});
      rd(2'd3, "R6 deferred not yet visible");
      rd(2'd3, "R6 deferred commit landed");

      // R8 status and ignored writes
      @(negedge clk); pll_locked = 1'b1; pll_out_active = 1'b0;
      rd(2'd2, "R8 status lock only");
      @(negedge clk); pll_locked = 1'b0; pll_out_active = 1'b1;
      rd(2'd2, "R8 status output only");
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFE);
      rd(2'd0, "R8 writes to status/readback ignored cfg");
      rd(2'd1, "R8 writes to status/readback ignored lane");
      rd(2'd3, "R10 readback width");

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [1:0]  s;
         logic [31:0] w;
         s = 2'($urandom % 4);
         w = $urandom;
         case ($urandom % 4)
            0: w[31:16] = 16'h0001;
            1: w[31:16] = 16'h0780;
            2: w[31:16] = 16'h07FF;
            default: ;
         endcase
         if ($urandom % 2 == 0) begin
            @(negedge clk);
            pll_locked = 1'($urandom); pll_out_active = 1'($urandom);
         end
         if ($urandom % 5 == 0) begin
            @(negedge clk); bus_valid = 1'b0;
            @(posedge clk); model_edge(1'b0, 2'd0, '0);
         end
         wr(s, w);
         if ($urandom % 2 == 0) rd(2'($urandom % 4), "R1/R4/R5/R6/R10 random read");
      end

      // R9 reset mid-run
      wr(2'd0, {16'h07FE, 16'(4'hF << 7) | 16'(6'd63 << 1)});
      wr(2'd0, 32'h0001_0001);
      rd(2'd3, "R4 top address commit");
      do_reset();
      rd(2'd0, "R9 cfg cleared");
      rd(2'd1, "R9 lane cleared");
      wr(2'd0, {16'h007E, 16'(6'd63 << 1)});
      rd(2'd3, "R9 array entry 63 cleared");
      wr(2'd0, {16'h007E, 16'(6'd5 << 1)});
      rd(2'd3, "R9 array entry 5 cleared");

      @(negedge clk); bus_valid = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule